// File: doc/BRIEF.md
# SDRAM Bank State Tracker and Command Checker

This block watches the command pins of a synchronous DRAM bus and keeps a model of every bank's state. On each clock with the clock enable in force it decodes the chip-select and the three strobes into a command code, works out which bank or banks the command addresses (bank bits, plus the A10 line for precharge-all and auto-precharge), and decides whether that command is legal for the present state of the addressed bank and for the global timing windows. Legal commands move the bank state machines; illegal ones are flagged with a one-cycle pulse and leave every bank unchanged.

Row opening, precharge and refresh are transient states that expire after a parameterised number of clock cycles. Read and write bursts end when the caller raises the per-bank burst-done input; a burst issued with auto-precharge then falls through to the precharging state on its own. The block is meant to sit beside a memory controller or a bus monitor as a protocol watchdog; it has no memory array and no data path.

Top module: `sdram_bank_tracker`

## Requirements
- R1: Commands decode as {ras_n,cas_n,we_n}: 011 activate (code 1), 101 read (2), 100 write (3), 010 precharge (4), 001 refresh (5), 000 mode write (6), 110 reserved (7); cs_n high or 111 gives no-op (0). The code appears on cmd_code one clock after it is sampled.
- R2: Bank bits 0..3 address bank0..bank3; bank i's state is bank_state[4i+3:4i] with encoding idle 0, opening 1, open 2, reading 3, writing 4, reading-autoprecharge 5, writing-autoprecharge 6, precharging 7, refreshing 8; all_idle is 1 exactly when every bank reads 0.
- R3: An accepted activate puts the bank in opening for T_RCD clocks, after which it is open.
- R4: A read or write to an open, reading or writing bank enters reading/writing (A10 low) or the auto-precharge variant (A10 high); burst_done then returns it to open, or for the auto-precharge variants to precharging.
- R5: Precharge with A10 low closes the addressed bank, with A10 high all banks; a closing bank returns to idle after T_RP clocks, and precharge of an idle or already-precharging bank is a legal no-op.
- R6: Refresh is legal only with all banks idle; it puts every bank in refreshing for T_RC clocks.
- R7: A mode write is legal only with all banks idle, and an activate within T_MRD clocks of it is illegal.
- R8: An activate sooner than T_RRD clocks after the previous accepted activate is illegal.
- R9: Activate to a non-idle bank, read or write to a bank that is not open/reading/writing, precharge reaching an opening, auto-precharging or refreshing bank, and the reserved code are illegal.
- R10: An illegal command raises illegal for one clock and changes no bank state.
- R11: When cke was low at the previous clock, the present command is ignored (code 0, no illegal) and all timers and burst_done handling pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable, takes effect one clock later |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Precharge-all / auto-precharge select |
| burst_done | input | 2**BA_W | Per-bank end-of-burst strobe |
| bank_state | output | 4*2**BA_W | Packed per-bank state codes |
| all_idle | output | 1 | Every bank idle |
| illegal | output | 1 | Last command was illegal |
| cmd_code | output | 3 | Last decoded command |

## Verification
Every result of a command sampled at clock edge k (cmd_code, illegal and the new bank states) is registered at that same edge, so the bench drives pins on the falling edge and reads the outputs on the following falling edge. A transient state entered at edge k with a limit of T clocks is still visible after edge k+T-1 and gone after edge k+T, and the bench checks both sides of that boundary for opening, precharging and refreshing, as well as the T_MRD and T_RRD windows by probing the last illegal and the first legal edge. Clock-enable gating is checked one edge late, matching the registered enable.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5,
        CMD_MRS = 3'd6,
        CMD_BST = 3'd7
    } cmd_e;

    localparam int ST_W = 4;

    typedef enum logic [ST_W-1:0] {
        BK_IDLE    = 4'd0,
        BK_OPENING = 4'd1,
        BK_OPEN    = 4'd2,
        BK_RD      = 4'd3,
        BK_WR      = 4'd4,
        BK_RD_AP   = 4'd5,
        BK_WR_AP   = 4'd6,
        BK_CLOSING = 4'd7,
        BK_REFRESH = 4'd8
    } bank_st_e;

    function automatic cmd_e decode_pins(input logic cs_n, input logic ras_n,
                                         input logic cas_n, input logic we_n);
        if (cs_n) return CMD_NOP;
        case ({ras_n, cas_n, we_n})
            3'b011:  return CMD_ACT;
            3'b101:  return CMD_RD;
            3'b100:  return CMD_WR;
            3'b010:  return CMD_PRE;
            3'b001:  return CMD_REF;
            3'b000:  return CMD_MRS;
            3'b110:  return CMD_BST;
            default: return CMD_NOP;
        endcase
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdram_trk_decode.sv
module sdram_trk_decode
    import sdram_trk_pkg::*;
(
    input  logic en,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e op
);
    always_comb begin
        op = en ? decode_pins(cs_n, ras_n, cas_n, we_n) : CMD_NOP;
    end
endmodule

// File: rtl/sdram_trk_guard.sv
module sdram_trk_guard #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          busy
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (en && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/sdram_trk_bank.sv
module sdram_trk_bank
    import sdram_trk_pkg::*;
#(
    parameter int CW    = 4,
    parameter int T_RP  = 3,
    parameter int T_RCD = 3,
    parameter int T_RC  = 9
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  cmd_e     op,
    input  logic     hit,
    input  logic     pre_hit,
    input  logic     a10,
    input  logic     accept,
    input  logic     burst_done,
    output bank_st_e st,
    output logic     reject
);
    logic [CW-1:0] cnt;

    always_comb begin
        reject = 1'b0;
        case (op)
            CMD_ACT: reject = hit && (st != BK_IDLE);
            CMD_RD, CMD_WR:
                reject = hit && !(st inside {BK_OPEN, BK_RD, BK_WR});
            CMD_PRE:
                reject = pre_hit && (st inside {BK_OPENING, BK_RD_AP, BK_WR_AP, BK_REFRESH});
            default: reject = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= BK_IDLE;
            cnt <= '0;
        end else if (en) begin
            if (accept && op == CMD_REF) begin
                st  <= BK_REFRESH;
                cnt <= CW'(T_RC - 1);
            end else if (accept && op == CMD_ACT && hit) begin
                st  <= BK_OPENING;
                cnt <= CW'(T_RCD - 1);
            end else if (accept && op == CMD_RD && hit) begin
                st  <= a10 ? BK_RD_AP : BK_RD;
            end else if (accept && op == CMD_WR && hit) begin
                st  <= a10 ? BK_WR_AP : BK_WR;
            end else if (accept && op == CMD_PRE && pre_hit &&
                         (st inside {BK_OPEN, BK_RD, BK_WR})) begin
                st  <= BK_CLOSING;
                cnt <= CW'(T_RP - 1);
            end else begin
                case (st)
                    BK_OPENING, BK_CLOSING, BK_REFRESH: begin
                        if (cnt == '0) st <= (st == BK_OPENING) ? BK_OPEN : BK_IDLE;
                        else           cnt <= cnt - 1'b1;
                    end
                    BK_RD, BK_WR: begin
                        if (burst_done) st <= BK_OPEN;
                    end
                    BK_RD_AP, BK_WR_AP: begin
                        if (burst_done) begin
                            st  <= BK_CLOSING;
                            cnt <= CW'(T_RP - 1);
                        end
                    end
                    default: st <= st;
                endcase
            end
        end
    end
endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
    import sdram_trk_pkg::*;
#(
    parameter int BA_W  = 2,
    parameter int T_RP  = 3,
    parameter int T_RCD = 3,
    parameter int T_RC  = 9,
    parameter int T_RRD = 2,
    parameter int T_MRD = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cke,
    input  logic                       cs_n,
    input  logic                       ras_n,
    input  logic                       cas_n,
    input  logic                       we_n,
    input  logic [BA_W-1:0]            ba,
    input  logic                       a10,
    input  logic [(2**BA_W)-1:0]       burst_done,
    output logic [ST_W*(2**BA_W)-1:0]  bank_state,
    output logic                       all_idle,
    output logic                       illegal,
    output logic [2:0]                 cmd_code
);
    localparam int NB    = 2 ** BA_W;
    localparam int T_MAX = max_of(max_of(max_of(T_RC, T_RP), max_of(T_RCD, T_RRD)), T_MRD);
    localparam int CW    = $clog2(T_MAX) + 1;

    logic     cke_q;
    logic     en;
    cmd_e     op;
    bank_st_e st [NB];
    logic [NB-1:0] reject;
    logic     global_bad;
    logic     bad;
    logic     accept;
    logic     rrd_busy;
    logic     mrd_busy;

    always_ff @(posedge clk) begin
        if (rst) cke_q <= 1'b1;
        else     cke_q <= cke;
    end
    assign en = cke_q;

    sdram_trk_decode u_dec (
        .en(en), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .op(op)
    );

    for (genvar i = 0; i < NB; i++) begin : g_bank
        logic hit;
        assign hit = (ba == BA_W'(i));

        sdram_trk_bank #(
            .CW(CW), .T_RP(T_RP), .T_RCD(T_RCD), .T_RC(T_RC)
        ) u_bank (
            .clk(clk), .rst(rst), .en(en), .op(op),
            .hit(hit), .pre_hit(hit | a10), .a10(a10),
            .accept(accept), .burst_done(burst_done[i]),
            .st(st[i]), .reject(reject[i])
        );

        assign bank_state[i*ST_W +: ST_W] = st[i];
    end

    always_comb begin
        all_idle = 1'b1;
        for (int i = 0; i < NB; i++) begin
            if (st[i] != BK_IDLE) all_idle = 1'b0;
        end
    end

    always_comb begin
        global_bad = 1'b0;
        case (op)
            CMD_REF, CMD_MRS: global_bad = !all_idle;
            CMD_ACT:          global_bad = rrd_busy || mrd_busy;
            CMD_BST:          global_bad = 1'b1;
            default:          global_bad = 1'b0;
        endcase
    end

    assign bad    = (|reject) || global_bad;
    assign accept = en && !bad;

    sdram_trk_guard #(.CW(CW)) u_rrd (
        .clk(clk), .rst(rst), .en(en),
        .load(accept && op == CMD_ACT), .load_val(CW'(T_RRD - 1)), .busy(rrd_busy)
    );

    sdram_trk_guard #(.CW(CW)) u_mrd (
        .clk(clk), .rst(rst), .en(en),
        .load(accept && op == CMD_MRS), .load_val(CW'(T_MRD - 1)), .busy(mrd_busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            illegal  <= 1'b0;
            cmd_code <= CMD_NOP;
        end else begin
            illegal  <= en && bad;
            cmd_code <= op;
        end
    end
endmodule

// File: rtl/sdram_bank_tracker_chk.sv
module sdram_bank_tracker_chk #(
    parameter int NB    = 4,
    parameter int SW    = 4,
    parameter int T_RRD = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [NB*SW-1:0] bank_state,
    input logic             all_idle,
    input logic             illegal,
    input logic [2:0]       cmd_code
);
    logic all_refreshing;

    always_comb begin
        all_refreshing = 1'b1;
        for (int i = 0; i < NB; i++) begin
            if (bank_state[i*SW +: SW] != SW'(8)) all_refreshing = 1'b0;
        end
    end

    a_r10_illegal_holds_state: assert property (@(posedge clk) disable iff (rst)
        illegal |-> $stable(bank_state));

    a_r1_illegal_has_command: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (cmd_code != 3'd0));

    a_r6_refresh_all_banks: assert property (@(posedge clk) disable iff (rst)
        (cmd_code == 3'd5 && !illegal) |-> all_refreshing);

    a_r7_mode_write_when_idle: assert property (@(posedge clk) disable iff (rst)
        (cmd_code == 3'd6 && !illegal) |-> all_idle);

    a_r8_activate_spacing: assert property (@(posedge clk) disable iff (rst)
        (T_RRD > 1 && cmd_code == 3'd1 && !illegal) |=> !(cmd_code == 3'd1 && !illegal));
endmodule

bind sdram_bank_tracker sdram_bank_tracker_chk #(
    .NB(2 ** BA_W), .SW(sdram_trk_pkg::ST_W), .T_RRD(T_RRD)
) u_chk (
    .clk(clk), .rst(rst), .bank_state(bank_state), .all_idle(all_idle),
    .illegal(illegal), .cmd_code(cmd_code)
);

// File: tb/sdram_bank_tracker_tb.sv
module sdram_bank_tracker_tb;
    localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3,
                           PRE = 3'd4, REF = 3'd5, MRS = 3'd6, BST = 3'd7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cke = 1'b1;
    logic        cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = 2'd0;
    logic        a10 = 1'b0;
    logic [3:0]  burst_done = 4'd0;
    logic [15:0] bank_state;
    logic        all_idle, illegal;
    logic [2:0]  cmd_code;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    sdram_bank_tracker u_dut (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10), .burst_done(burst_done),
        .bank_state(bank_state), .all_idle(all_idle), .illegal(illegal),
        .cmd_code(cmd_code)
    );

    function automatic int bst(input int i);
        return int'(bank_state[i*4 +: 4]);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic [2:0] c, input logic [1:0] b, input logic a,
                        input logic [3:0] bd, input logic ck);
        cs_n = 1'b0;
        case (c)
            ACT:     {ras_n, cas_n, we_n} = 3'b011;
            RD:      {ras_n, cas_n, we_n} = 3'b101;
            WR:      {ras_n, cas_n, we_n} = 3'b100;
            PRE:     {ras_n, cas_n, we_n} = 3'b010;
            REF:     {ras_n, cas_n, we_n} = 3'b001;
            MRS:     {ras_n, cas_n, we_n} = 3'b000;
            BST:     {ras_n, cas_n, we_n} = 3'b110;
            default: {ras_n, cas_n, we_n} = 3'b111;
        endcase
        ba = b; a10 = a; burst_done = bd; cke = ck;
        @(posedge clk);
        @(negedge clk);
        {ras_n, cas_n, we_n} = 3'b111;
        burst_done = 4'd0; cke = 1'b1; a10 = 1'b0;
    endtask

    task automatic cmd(input logic [2:0] c, input logic [1:0] b, input logic a);
        step(c, b, a, 4'd0, 1'b1);
    endtask

    task automatic nops(input int n);
        for (int i = 0; i < n; i++) cmd(NOP, 2'd0, 1'b0);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R2 reset states", int'(bank_state), 0);
        check("R2 reset all_idle", int'(all_idle), 1);
        check("R10 reset illegal", int'(illegal), 0);
        check("R1 reset cmd_code", int'(cmd_code), 0);
    endtask

    task automatic t_activate;
        cmd(ACT, 2'd1, 1'b0);
        check("R1 act code", int'(cmd_code), 1);
        check("R3 bank1 opening", bst(1), 1);
        check("R2 all_idle drops", int'(all_idle), 0);
        cmd(PRE, 2'd1, 1'b0);
        check("R9 pre to opening bank illegal", int'(illegal), 1);
        check("R10 opening bank kept", bst(1), 1);
        nops(1);
        check("R3 still opening at T_RCD-1", bst(1), 1);
        nops(1);
        check("R3 open at T_RCD", bst(1), 2);
    endtask

    task automatic t_rrd;
        cmd(ACT, 2'd2, 1'b0);
        check("R8 first act legal", int'(illegal), 0);
        cmd(ACT, 2'd3, 1'b0);
        check("R8 act inside T_RRD illegal", int'(illegal), 1);
        check("R10 bank3 unchanged", bst(3), 0);
        cmd(ACT, 2'd3, 1'b0);
        check("R8 act at T_RRD legal", int'(illegal), 0);
        check("R2 bank3 opening", bst(3), 1);
        nops(3);
        check("R3 bank2 open", bst(2), 2);
        check("R3 bank3 open", bst(3), 2);
    endtask

    task automatic t_illegal;
        cmd(ACT, 2'd1, 1'b0);
        check("R9 act to open bank", int'(illegal), 1);
        check("R10 open bank kept", bst(1), 2);
        cmd(BST, 2'd0, 1'b0);
        check("R1 reserved code", int'(cmd_code), 7);
        check("R9 reserved illegal", int'(illegal), 1);
        cmd(REF, 2'd0, 1'b0);
        check("R6 refresh while open illegal", int'(illegal), 1);
        check("R10 refresh rejected keeps bank1", bst(1), 2);
        cmd(RD, 2'd0, 1'b0);
        check("R9 read to idle bank", int'(illegal), 1);
    endtask

    task automatic t_read_ap;
        cmd(RD, 2'd1, 1'b1);
        check("R1 read code", int'(cmd_code), 2);
        check("R4 read autoprecharge state", bst(1), 5);
        cmd(RD, 2'd1, 1'b0);
        check("R9 read during autoprecharge burst", int'(illegal), 1);
        step(NOP, 2'd0, 1'b0, 4'b0010, 1'b1);
        check("R4 burst end to precharging", bst(1), 7);
        nops(2);
        check("R5 precharging at T_RP-1", bst(1), 7);
        nops(1);
        check("R5 idle at T_RP", bst(1), 0);
    endtask

    task automatic t_write;
        cmd(WR, 2'd2, 1'b0);
        check("R1 write code", int'(cmd_code), 3);
        check("R4 writing state", bst(2), 4);
        step(NOP, 2'd0, 1'b0, 4'b0100, 1'b1);
        check("R4 burst end to open", bst(2), 2);
    endtask

    task automatic t_precharge;
        cmd(PRE, 2'd0, 1'b0);
        check("R5 precharge idle bank legal", int'(illegal), 0);
        check("R5 idle bank stays idle", bst(0), 0);
        cmd(PRE, 2'd0, 1'b1);
        check("R1 precharge code", int'(cmd_code), 4);
        check("R5 all: bank2 closing", bst(2), 7);
        check("R5 all: bank3 closing", bst(3), 7);
        check("R5 all: bank1 idle", bst(1), 0);
        nops(3);
        check("R5 all banks idle", int'(bank_state), 0);
        check("R2 all_idle back", int'(all_idle), 1);
    endtask

    task automatic t_refresh;
        cmd(REF, 2'd0, 1'b0);
        check("R1 refresh code", int'(cmd_code), 5);
        check("R6 all refreshing", int'(bank_state), 16'h8888);
        cmd(ACT, 2'd0, 1'b0);
        check("R9 act during refresh", int'(illegal), 1);
        nops(7);
        check("R6 refreshing at T_RC-1", bst(0), 8);
        nops(1);
        check("R6 idle at T_RC", int'(bank_state), 0);
    endtask

    task automatic t_mode;
        cmd(MRS, 2'd0, 1'b0);
        check("R1 mode code", int'(cmd_code), 6);
        check("R7 mode write legal when idle", int'(illegal), 0);
        nops(1);
        cmd(ACT, 2'd0, 1'b0);
        check("R7 act at T_MRD-1 illegal", int'(illegal), 1);
        cmd(ACT, 2'd0, 1'b0);
        check("R7 act at T_MRD legal", int'(illegal), 0);
        check("R3 bank0 opening", bst(0), 1);
        cmd(MRS, 2'd0, 1'b0);
        check("R7 mode write while busy illegal", int'(illegal), 1);
    endtask

    task automatic t_cke;
        nops(3);
        check("R3 bank0 open", bst(0), 2);
        step(NOP, 2'd0, 1'b0, 4'd0, 1'b0);
        cmd(PRE, 2'd0, 1'b0);
        check("R11 suspended code", int'(cmd_code), 0);
        check("R11 suspended no illegal", int'(illegal), 0);
        check("R11 suspended command ignored", bst(0), 2);
        cmd(PRE, 2'd0, 1'b0);
        check("R5 precharge after resume", bst(0), 7);
        step(NOP, 2'd0, 1'b0, 4'd0, 1'b0);
        nops(2);
        check("R11 timer paused", bst(0), 7);
        nops(1);
        check("R11 timer resumes", bst(0), 0);
    endtask

    task automatic t_deselect;
        cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b011; ba = 2'd0;
        @(posedge clk);
        @(negedge clk);
        cs_n = 1'b0; {ras_n, cas_n, we_n} = 3'b111;
        check("R1 deselect code", int'(cmd_code), 0);
        check("R1 deselect no effect", bst(0), 0);
    endtask

    initial begin
        #2000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset;
        t_activate;
        t_rrd;
        t_illegal;
        t_read_ap;
        t_write;
        t_precharge;
        t_refresh;
        t_mode;
        t_cke;
        t_deselect;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule